// File: doc/BRIEF.md
# Flash Operation Status Word Generator

This block forms the byte that a host sees when it reads a flash array while an embedded program or erase is running, is suspended, or has failed. A separate controller reports the current operation phase, the data byte most recently loaded for programming, and the address of the word or sector under operation. On every read the block either returns a status word or passes the array data through unchanged. The choice depends on the phase and on whether the read address falls inside the sector under operation. The block also drives an active-low busy line.

Two bits of the status word invert from one read to the next, so software can poll for completion. Bit 6 marks any program or erase in progress. Bit 2 marks erase activity and suspended sectors. A one-bit polling mode, held in a register of its own, selects how bit 7 reports progress. The same mode decides whether a successful operation drops back to array reads by itself or holds status until the host sends an identify-exit. Sector geometry is parameterised: one 32K-word slot is split into eight 4K-word sectors, either at the bottom of the map (the default) or at the top.

Top module: `flsts_top`

## Requirements
- R1: While `op_state`=1 (program), bit 7 is the inverse of `last_data[7]` in mode 0 and reads 0 in mode 1; bit 5 reads 0 and bit 2 reads 1.
- R2: While `op_state`=2 (erase), bits 7 and 5 read 0 in both modes.
- R3: Bit 6 holds a flag that inverts after each completed read (falling read strobe) taken in program or erase, and keeps its value otherwise; bit 6 shows this flag in program, erase, fail and completion-hold reads.
- R4: While `op_state`=3 (erase suspended), a read inside the operated sector returns bits 7,6,5 = 1,1,0 with bit 2 showing a second flag that inverts after that read. A read outside the sector returns `array_data`.
- R5: While `op_state`=4 (program suspended), a read inside the operated sector returns bit 7 = inverse of `last_data[7]` in mode 0 or 1 in mode 1, bit 6 = 1, bit 5 = 0, bit 2 = second flag (inverted after the read). A read outside the sector returns `array_data`.
- R6: While `op_state`=5 (failed), every read returns bit 5 = 1, bit 7 = 0, and both flags frozen.
- R7: `busy_n` is 0 exactly while `op_state` is 1 or 2.
- R8: With `op_state`=0 (idle) and no completion hold, reads return `array_data`.
- R9: The polling mode is 0 after `rst`, loads `cfg_val` when `cfg_we` is high, and is not changed by `pin_rst`.
- R10: In mode 1 a move from program or erase to idle starts a completion hold. During the hold, reads return bit 7 = 1 and bit 5 = 0, and the flags stay frozen until `id_exit`. In mode 0 no hold starts.
- R11: Sector match: word addresses 0x00000-0x07FFF form eight 4K-word sectors, and every other 32K-word slot is one sector (bottom-boot default).
- R12: `rst` or `pin_rst` clears both flags to 0 and ends a completion hold. All status bits not named above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| pin_rst | input | 1 | Device reset request; clears flags and hold, keeps mode |
| cfg_we | input | 1 | Load polling mode |
| cfg_val | input | 1 | New polling mode value |
| id_exit | input | 1 | Identify-exit; ends a completion hold |
| op_state | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program suspended, 5 failed |
| last_data | input | 8 | Byte most recently loaded for programming |
| op_addr | input | ADDR_W | Word address of the operation target |
| rd_addr | input | ADDR_W | Word address being read |
| rd_strobe | input | 1 | High while a read is in progress |
| array_data | input | 8 | Array contents at `rd_addr` |
| dout | output | 8 | Status or array byte |
| busy_n | output | 1 | Low while program or erase runs |

## Verification
`dout` is combinational from the inputs and the stored flags, so it is sampled one time unit after the first rising edge of a strobe, with the address and phase set up at the preceding falling clock edge. The flags change on the rising edge that first sees the strobe low. The bench lowers the strobe at a falling edge and waits past the next rising edge before the next read, so each read sees the flags left by the one before. Mode loads and the completion hold take effect one rising edge after their inputs are applied. `busy_n` is checked in the same sample as `dout`.

// File: rtl/flsts_pkg.sv
package flsts_pkg;

    localparam int DQ_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_ESUSP = 3'd3,
        OP_PSUSP = 3'd4,
        OP_FAIL  = 3'd5
    } op_e;

    typedef enum logic {
        POLL_INV  = 1'b0,
        POLL_DONE = 1'b1
    } poll_mode_e;

    typedef struct packed {
        logic       poll;
        logic       tog_a;
        logic       fail;
        logic [1:0] zero_hi;
        logic       tog_b;
        logic [1:0] zero_lo;
    } stat_t;

    function automatic logic op_running(op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

    function automatic logic op_suspended(op_e op);
        return (op == OP_ESUSP) || (op == OP_PSUSP);
    endfunction

    function automatic logic flip_b_cond(op_e op, logic in_sect);
        return (op == OP_ERASE) || (op_suspended(op) && in_sect);
    endfunction

endpackage

// File: rtl/flsts_sector_cmp.sv
module flsts_sector_cmp #(
    parameter int ADDR_W   = 19,
    parameter int SMALL_W  = 12,
    parameter int BIG_W    = 15,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same
);
    localparam int SLOT_W = ADDR_W - BIG_W;

    logic [SLOT_W-1:0] boot_slot;
    logic              slot_eq;
    logic              sub_eq;

    generate
        if (TOP_BOOT) begin : g_top
            assign boot_slot = {SLOT_W{1'b1}};
        end else begin : g_bottom
            assign boot_slot = '0;
        end
    endgenerate

    assign slot_eq = addr_a[ADDR_W-1:BIG_W] == addr_b[ADDR_W-1:BIG_W];
    assign sub_eq  = addr_a[BIG_W-1:SMALL_W] == addr_b[BIG_W-1:SMALL_W];
    assign same    = slot_eq && ((addr_a[ADDR_W-1:BIG_W] != boot_slot) || sub_eq);
endmodule

// File: rtl/flsts_toggle.sv
module flsts_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (flip)
            q <= ~q;
    end
endmodule

// File: rtl/flsts_mode_reg.sv
module flsts_mode_reg
    import flsts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       val,
    output poll_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= POLL_INV;
        else if (we)
            mode <= poll_mode_e'(val);
    end
endmodule

// File: rtl/flsts_hold.sv
module flsts_hold
    import flsts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  op_e        op,
    input  poll_mode_e mode,
    output logic       hold
);
    op_e op_prev;

    always_ff @(posedge clk) begin
        if (rst)
            op_prev <= OP_IDLE;
        else
            op_prev <= op;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            hold <= 1'b0;
        else if (op_running(op_prev) && (op == OP_IDLE) && (mode == POLL_DONE))
            hold <= 1'b1;
    end
endmodule

// File: rtl/flsts_fmt.sv
module flsts_fmt
    import flsts_pkg::*;
(
    input  op_e             op,
    input  poll_mode_e      mode,
    input  logic            hold,
    input  logic            in_sect,
    input  logic            last7,
    input  logic            tog_a,
    input  logic            tog_b,
    input  logic [DQ_W-1:0] array_data,
    output logic [DQ_W-1:0] dout
);
    stat_t st;
    logic  use_st;

    always_comb begin
        st     = '0;
        use_st = 1'b0;
        unique case (op)
            OP_PROG: begin
                use_st   = 1'b1;
                st.poll  = (mode == POLL_INV) ? ~last7 : 1'b0;
                st.tog_a = tog_a;
                st.tog_b = 1'b1;
            end
            OP_ERASE: begin
                use_st   = 1'b1;
                st.tog_a = tog_a;
                st.tog_b = tog_b;
            end
            OP_ESUSP: begin
                use_st   = in_sect;
                st.poll  = 1'b1;
                st.tog_a = 1'b1;
                st.tog_b = tog_b;
            end
            OP_PSUSP: begin
                use_st   = in_sect;
                st.poll  = (mode == POLL_INV) ? ~last7 : 1'b1;
                st.tog_a = 1'b1;
                st.tog_b = tog_b;
            end
            OP_FAIL: begin
                use_st   = 1'b1;
                st.fail  = 1'b1;
                st.tog_a = tog_a;
                st.tog_b = tog_b;
            end
            default: begin
                use_st   = hold;
                st.poll  = 1'b1;
                st.tog_a = tog_a;
                st.tog_b = tog_b;
            end
        endcase
        dout = use_st ? st : array_data;
    end
endmodule

// File: rtl/flsts_top.sv
module flsts_top
    import flsts_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SMALL_W  = 12,
    parameter int BIG_W    = 15,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst,
    input  logic              cfg_we,
    input  logic              cfg_val,
    input  logic              id_exit,
    input  logic [2:0]        op_state,
    input  logic [7:0]        last_data,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_strobe,
    input  logic [7:0]        array_data,
    output logic [7:0]        dout,
    output logic              busy_n
);
    op_e        op;
    poll_mode_e cfg_mode;
    logic       in_sect;
    logic       strobe_q;
    logic       rd_fall;
    logic       tog_a_q;
    logic       tog_b_q;
    logic       hold_q;

    assign op = op_e'(op_state);

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= rd_strobe;
    end

    assign rd_fall = strobe_q && !rd_strobe;

    flsts_sector_cmp #(
        .ADDR_W  (ADDR_W),
        .SMALL_W (SMALL_W),
        .BIG_W   (BIG_W),
        .TOP_BOOT(TOP_BOOT)
    ) u_sect (
        .addr_a(rd_addr),
        .addr_b(op_addr),
        .same  (in_sect)
    );

    flsts_mode_reg u_mode (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .val (cfg_val),
        .mode(cfg_mode)
    );

    flsts_toggle u_tog_a (
        .clk (clk),
        .rst (rst),
        .clr (pin_rst),
        .flip(rd_fall && op_running(op)),
        .q   (tog_a_q)
    );

    flsts_toggle u_tog_b (
        .clk (clk),
        .rst (rst),
        .clr (pin_rst),
        .flip(rd_fall && flip_b_cond(op, in_sect)),
        .q   (tog_b_q)
    );

    flsts_hold u_hold (
        .clk (clk),
        .rst (rst),
        .clr (pin_rst || id_exit),
        .op  (op),
        .mode(cfg_mode),
        .hold(hold_q)
    );

    flsts_fmt u_fmt (
        .op        (op),
        .mode      (cfg_mode),
        .hold      (hold_q),
        .in_sect   (in_sect),
        .last7     (last_data[7]),
        .tog_a     (tog_a_q),
        .tog_b     (tog_b_q),
        .array_data(array_data),
        .dout      (dout)
    );

    assign busy_n = !op_running(op);
endmodule

// File: rtl/flsts_chk.sv
module flsts_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_rst,
    input logic       cfg_we,
    input logic [2:0] op_state,
    input logic       rd_strobe,
    input logic [7:0] dout,
    input logic       busy_n,
    input logic       in_sect,
    input logic       tog_a_q,
    input logic       cfg_mode
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b0;
        else
            seen_q <= rd_strobe;
    end

    // R7
    busy_low_chk: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd1 || op_state == 3'd2) |-> !busy_n);

    // R7
    busy_high_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_state == 3'd1 || op_state == 3'd2) |-> busy_n);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(seen_q && !rd_strobe) && !pin_rst) |=> $stable(tog_a_q));

    // R9
    mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_rst && !cfg_we) |=> $stable(cfg_mode));

    // R4
    esusp_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd3 && in_sect && rd_strobe) |-> dout[7:5] == 3'b110);

    // R6
    fail_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd5) |-> (dout[5] && !dout[7] && busy_n));

    // R2
    erase_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd2) |-> (!dout[7] && !dout[5]));
endmodule

bind flsts_top flsts_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_rst  (pin_rst),
    .cfg_we   (cfg_we),
    .op_state (op_state),
    .rd_strobe(rd_strobe),
    .dout     (dout),
    .busy_n   (busy_n),
    .in_sect  (in_sect),
    .tog_a_q  (tog_a_q),
    .cfg_mode (cfg_mode)
);

// File: tb/flsts_top_bench.sv
module flsts_top_bench;
    localparam int AW = 19;

    typedef struct packed {
        logic [3:0]    req;
        logic [2:0]    st;
        logic          cfg;
        logic [AW-1:0] rd;
        logic [AW-1:0] op;
        logic [7:0]    last;
        logic [7:0]    arr;
        logic [7:0]    mask;
        logic [7:0]    exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        {4'd8,  3'd0, 1'b0, 19'h00100, 19'h00000, 8'h00, 8'h5A, 8'hFF, 8'h5A}, // R8
        {4'd1,  3'd1, 1'b0, 19'h00100, 19'h00100, 8'h00, 8'h00, 8'hBF, 8'h84}, // R1
        {4'd1,  3'd1, 1'b0, 19'h00100, 19'h00100, 8'h80, 8'h00, 8'hBF, 8'h04}, // R1
        {4'd1,  3'd1, 1'b1, 19'h00100, 19'h00100, 8'h00, 8'h00, 8'hBF, 8'h04}, // R1
        {4'd2,  3'd2, 1'b0, 19'h40000, 19'h40000, 8'h00, 8'hFF, 8'hBB, 8'h00}, // R2
        {4'd2,  3'd2, 1'b1, 19'h40000, 19'h40000, 8'h00, 8'hFF, 8'hBB, 8'h00}, // R2
        {4'd4,  3'd3, 1'b0, 19'h01FFF, 19'h01234, 8'h00, 8'h00, 8'hFB, 8'hC0}, // R4
        {4'd11, 3'd3, 1'b0, 19'h02000, 19'h01234, 8'h00, 8'h3C, 8'hFF, 8'h3C}, // R11
        {4'd4,  3'd3, 1'b0, 19'h47FFF, 19'h40000, 8'h00, 8'h00, 8'hFB, 8'hC0}, // R4
        {4'd11, 3'd3, 1'b0, 19'h48000, 19'h40000, 8'h00, 8'hA5, 8'hFF, 8'hA5}, // R11
        {4'd11, 3'd3, 1'b0, 19'h00FFF, 19'h00010, 8'h00, 8'h00, 8'hFB, 8'hC0}, // R11
        {4'd11, 3'd3, 1'b0, 19'h01000, 19'h00010, 8'h00, 8'h11, 8'hFF, 8'h11}, // R11
        {4'd5,  3'd4, 1'b0, 19'h27FFF, 19'h20000, 8'h00, 8'h00, 8'hFB, 8'hC0}, // R5
        {4'd5,  3'd4, 1'b0, 19'h27FFF, 19'h20000, 8'hFF, 8'h00, 8'hFB, 8'h40}, // R5
        {4'd5,  3'd4, 1'b1, 19'h27FFF, 19'h20000, 8'hFF, 8'h00, 8'hFB, 8'hC0}, // R5
        {4'd5,  3'd4, 1'b0, 19'h28000, 19'h20000, 8'h00, 8'h77, 8'hFF, 8'h77}, // R5
        {4'd6,  3'd5, 1'b0, 19'h00000, 19'h40000, 8'h00, 8'h00, 8'hBB, 8'h20}, // R6
        {4'd6,  3'd5, 1'b1, 19'h00000, 19'h40000, 8'h00, 8'h00, 8'hBB, 8'h20}, // R6
        {4'd8,  3'd0, 1'b0, 19'h00200, 19'h40000, 8'h00, 8'hE1, 8'hFF, 8'hE1}  // R8
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_rst = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_val = 1'b0;
    logic          id_exit = 1'b0;
    logic [2:0]    op_state = 3'd0;
    logic [7:0]    last_data = 8'h00;
    logic [AW-1:0] op_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_strobe = 1'b0;
    logic [7:0]    array_data = 8'h00;
    logic [7:0]    dout;
    logic          busy_n;

    int   checks = 0;
    int   errors = 0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;
    logic [7:0] got;
    logic got_busy;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    flsts_top #(.ADDR_W(AW)) u_flsts_top (
        .clk(clk), .rst(rst), .pin_rst(pin_rst), .cfg_we(cfg_we),
        .cfg_val(cfg_val), .id_exit(id_exit), .op_state(op_state),
        .last_data(last_data), .op_addr(op_addr), .rd_addr(rd_addr),
        .rd_strobe(rd_strobe), .array_data(array_data), .dout(dout),
        .busy_n(busy_n)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp, input logic [7:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h (mask %02h)", tag, act, exp, mask);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        rd_addr   = a;
        rd_strobe = 1'b1;
        @(posedge clk);
        #1;
        got      = dout;
        got_busy = busy_n;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // model update of the two flags after a read
    task automatic model_read(input logic [2:0] st, input logic insec);
        if (st == 3'd1 || st == 3'd2) m6 = ~m6;
        if (st == 3'd2 || ((st == 3'd3 || st == 3'd4) && insec)) m2 = ~m2;
    endtask

    task automatic set_cfg(input logic v);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_val = v;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) pin_rst = 1'b1; else id_exit = 1'b1;
        @(negedge clk);
        pin_rst = 1'b0;
        id_exit = 1'b0;
    endtask

    task automatic set_op(input logic [2:0] st, input logic [AW-1:0] oa,
                          input logic [7:0] ld, input logic [7:0] ad);
        @(negedge clk);
        op_state   = st;
        op_addr    = oa;
        last_data  = ld;
        array_data = ad;
    endtask

    task automatic status_read(input string tag, input logic [2:0] st,
                               input logic [AW-1:0] a, input logic insec,
                               input logic [7:0] exp);
        do_read(a);
        check(tag, got, exp, 8'hFF);
        model_read(st, insec);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        array_data = 8'h9C;
        // R8 reset state: idle passes array data, not busy
        do_read(19'h00040);
        check("R8 reset dout", got, 8'h9C, 8'hFF);
        check("R7 reset busy_n", {7'd0, got_busy}, 8'h01, 8'hFF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i].cfg);
            set_op(VEC[i].st, VEC[i].op, VEC[i].last, VEC[i].arr);
            pulse(1);
            do_read(VEC[i].rd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), got, VEC[i].exp, VEC[i].mask);
            // R7 busy per state
            check($sformatf("R7 busy vector %0d", i), {7'd0, got_busy},
                  {7'd0, !(VEC[i].st == 3'd1 || VEC[i].st == 3'd2)}, 8'hFF);
        end

        // R12 pin reset clears flags
        set_cfg(1'b0);
        pulse(0);
        m6 = 1'b0; m2 = 1'b0;
        set_op(3'd2, 19'h40000, 8'h00, 8'hFF);
        status_read("R12 flags cleared", 3'd2, 19'h40010, 1'b1, 8'h00);
        // R2 R3 successive erase reads invert both flags
        status_read("R3 erase read 2", 3'd2, 19'h40010, 1'b1, {1'b0, m6, 3'b000, m2, 2'b00});
        status_read("R2 erase read 3", 3'd2, 19'h40010, 1'b1, {1'b0, m6, 3'b000, m2, 2'b00});
        // R3 flags hold across idle cycles without reads
        repeat (6) @(posedge clk);
        status_read("R3 hold without read", 3'd2, 19'h40010, 1'b1, {1'b0, m6, 3'b000, m2, 2'b00});
        // R1 program: bit6 flips, bit2 reads 1
        set_op(3'd1, 19'h40000, 8'h80, 8'hFF);
        status_read("R1 program flag", 3'd1, 19'h40000, 1'b1, {1'b0, m6, 3'b000, 1'b1, 2'b00});
        status_read("R3 program flag next", 3'd1, 19'h40000, 1'b1, {1'b0, m6, 3'b000, 1'b1, 2'b00});
        // R4 erase suspend in-sector: bit2 flips, bit6 fixed 1
        set_op(3'd3, 19'h40000, 8'h00, 8'hFF);
        status_read("R4 esusp flag a", 3'd3, 19'h40004, 1'b1, {3'b110, 2'b00, m2, 2'b00});
        status_read("R4 esusp flag b", 3'd3, 19'h40004, 1'b1, {3'b110, 2'b00, m2, 2'b00});
        // R6 failure freezes both flags
        set_op(3'd5, 19'h40000, 8'h00, 8'hFF);
        status_read("R6 fail read a", 3'd5, 19'h12345, 1'b0, {1'b0, m6, 1'b1, 2'b00, m2, 2'b00});
        status_read("R6 fail read b", 3'd5, 19'h12345, 1'b0, {1'b0, m6, 1'b1, 2'b00, m2, 2'b00});
        // R5 program suspend in-sector
        set_op(3'd4, 19'h40000, 8'h00, 8'hFF);
        status_read("R5 psusp flag", 3'd4, 19'h47000, 1'b1, {3'b110, 2'b00, m2, 2'b00});

        // R10 completion hold in mode 1
        set_cfg(1'b1);
        set_op(3'd1, 19'h00100, 8'h00, 8'h12);
        set_op(3'd0, 19'h00100, 8'h00, 8'h12);
        status_read("R10 hold read a", 3'd0, 19'h00100, 1'b1, {1'b1, m6, 3'b000, m2, 2'b00});
        check("R10 hold busy_n", {7'd0, got_busy}, 8'h01, 8'hFF);
        status_read("R10 hold read b", 3'd0, 19'h00100, 1'b1, {1'b1, m6, 3'b000, m2, 2'b00});
        pulse(1);
        status_read("R10 after exit", 3'd0, 19'h00100, 1'b1, 8'h12);
        // R10 mode 0: no hold
        set_cfg(1'b0);
        set_op(3'd2, 19'h00100, 8'h00, 8'h12);
        set_op(3'd0, 19'h00100, 8'h00, 8'h12);
        status_read("R10 mode0 auto return", 3'd0, 19'h00100, 1'b1, 8'h12);
        // R12 pin reset ends hold
        set_cfg(1'b1);
        set_op(3'd2, 19'h00100, 8'h00, 8'h12);
        set_op(3'd0, 19'h00100, 8'h00, 8'h12);
        pulse(0);
        m6 = 1'b0; m2 = 1'b0;
        status_read("R12 hold cleared", 3'd0, 19'h00100, 1'b1, 8'h12);

        // R9 mode survives pin reset, returns to 0 on power-up reset
        pulse(0);
        m6 = 1'b0; m2 = 1'b0;
        set_op(3'd1, 19'h00100, 8'h00, 8'h12);
        status_read("R9 mode kept over pin_rst", 3'd1, 19'h00100, 1'b1, {1'b0, m6, 3'b000, 1'b1, 2'b00});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m6 = 1'b0; m2 = 1'b0;
        status_read("R9 mode after rst", 3'd1, 19'h00100, 1'b1, {1'b1, m6, 3'b000, 1'b1, 2'b00});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule